// File: doc/BRIEF.md
# Limited Range Pixel Clamp

This block sits in a display output path and limits every colour component of a pixel stream to a legal code range before the pixel leaves the chip. Each pixel carries three 12-bit components (red, green, blue). A 3-bit format code picks the range. Three codes select the usual limited-range window (black at 16 and white at 235 in 8-bit terms) scaled to 8, 10 or 12 bits per component and left-aligned in the 12-bit word. One code takes separate lower and upper bounds for each channel from six bound inputs. The block does not rescale from full to limited range. It only limits values.

A pixel is accepted on any cycle with the input valid high and appears at the output one clock later, with the output valid high. Clamping applies only when the clamp enable is high. The no-clamp code, any undefined code, or a low enable passes data through untouched. Typical programmable settings are 0x010 for the lower bound and 0xFEF for the upper bound.

Top module: `pixel_range_clamp`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and all three output components are 0.
- R2: out_valid_o equals the value in_valid_i had at the previous rising clock edge.
- R3: When clamp_en_i is 0, an accepted pixel appears unchanged on the outputs one cycle later, for any format code.
- R4: With clamp_en_i at 1 and fmt_code_i equal to 0 (6-bit, no clamp), accepted data passes unchanged.
- R5: With clamp_en_i at 1 and fmt_code_i equal to 1, 2 or 3 (8, 10 or 12 bits per component), every component is limited to the range 0x100 to 0xEB0. This is 16..235 scaled to the depth and left-aligned in 12 bits.
- R6: With clamp_en_i at 1 and fmt_code_i equal to 7, each channel is limited to its own bounds: lo_r_i/hi_r_i, lo_g_i/hi_g_i and lo_b_i/hi_b_i.
- R7: Format codes 4, 5 and 6 behave as no clamp, and data passes unchanged.
- R8: A component equal to a bound, or between the bounds, passes unchanged.
- R9: A component below its lower bound becomes the lower bound. Otherwise, a component above its upper bound becomes the upper bound. When the lower bound exceeds the upper bound, the lower-bound test therefore wins.
- R10: While in_valid_i is 0, the output components keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_r_i | input | 12 | Red component in |
| in_g_i | input | 12 | Green component in |
| in_b_i | input | 12 | Blue component in |
| clamp_en_i | input | 1 | Clamp enable |
| fmt_code_i | input | 3 | Range format code |
| lo_r_i | input | 12 | Red lower bound, code 7 |
| hi_r_i | input | 12 | Red upper bound, code 7 |
| lo_g_i | input | 12 | Green lower bound, code 7 |
| hi_g_i | input | 12 | Green upper bound, code 7 |
| lo_b_i | input | 12 | Blue lower bound, code 7 |
| hi_b_i | input | 12 | Blue upper bound, code 7 |
| out_valid_o | output | 1 | Output pixel valid |
| out_r_o | output | 12 | Red component out |
| out_g_o | output | 12 | Green component out |
| out_b_o | output | 12 | Blue component out |

## Verification
The programmable-range assertion only makes a claim when the lower bound does not exceed the upper bound. An inverted pair has no window to check against. The bench drives inverted pairs only in the dedicated priority test, and the ordering there is compared against the reference model rather than the assertion. All other properties take the configuration inputs as sampled in the same cycle as the pixel. The stimulus therefore changes configuration only at the falling edge, together with the pixel it applies to.

// File: rtl/pclamp_pkg.sv
package pclamp_pkg;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_D8   = 3'd1,
    FMT_D10  = 3'd2,
    FMT_D12  = 3'd3,
    FMT_PROG = 3'd7
  } fmt_code_e;

  localparam int unsigned NUM_CH = 3;

  // black / white codes at 8 bits, scaled to depth then left-aligned to width
  function automatic int unsigned lim_lo(int unsigned depth, int unsigned width);
    return (16 << (depth - 8)) << (width - depth);
  endfunction

  function automatic int unsigned lim_hi(int unsigned depth, int unsigned width);
    return (235 << (depth - 8)) << (width - depth);
  endfunction

endpackage

// File: rtl/pclamp_bound_sel.sv
module pclamp_bound_sel
  import pclamp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic                           clamp_en_i,
  input  logic [2:0]                     fmt_code_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  prog_lo_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  prog_hi_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  lo_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  hi_o,
  output logic                           active_o
);

  localparam logic [DATA_W-1:0] LO_D8  = DATA_W'(lim_lo(8,  DATA_W));
  localparam logic [DATA_W-1:0] HI_D8  = DATA_W'(lim_hi(8,  DATA_W));
  localparam logic [DATA_W-1:0] LO_D10 = DATA_W'(lim_lo(10, DATA_W));
  localparam logic [DATA_W-1:0] HI_D10 = DATA_W'(lim_hi(10, DATA_W));
  localparam logic [DATA_W-1:0] LO_D12 = DATA_W'(lim_lo(12, DATA_W));
  localparam logic [DATA_W-1:0] HI_D12 = DATA_W'(lim_hi(12, DATA_W));

  always_comb begin
    active_o = 1'b0;
    lo_o     = '0;
    hi_o     = '1;
    if (clamp_en_i) begin
      case (fmt_code_i)
        FMT_D8: begin
          active_o = 1'b1;
          lo_o = {NUM_CH{LO_D8}};
          hi_o = {NUM_CH{HI_D8}};
        end
        FMT_D10: begin
          active_o = 1'b1;
          lo_o = {NUM_CH{LO_D10}};
          hi_o = {NUM_CH{HI_D10}};
        end
        FMT_D12: begin
          active_o = 1'b1;
          lo_o = {NUM_CH{LO_D12}};
          hi_o = {NUM_CH{HI_D12}};
        end
        FMT_PROG: begin
          active_o = 1'b1;
          lo_o = prog_lo_i;
          hi_o = prog_hi_i;
        end
        default: active_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pclamp_comp.sv
module pclamp_comp #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              active_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic [DATA_W-1:0] data_o
);

  // lower test first: an inverted window resolves to the lower bound
  always_comb begin
    data_o = data_i;
    if (active_i) begin
      if (data_i < lo_i)      data_o = lo_i;
      else if (data_i > hi_i) data_o = hi_i;
    end
  end

endmodule

// File: rtl/pixel_range_clamp.sv
module pixel_range_clamp
  import pclamp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_r_i,
  input  logic [DATA_W-1:0] in_g_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic              clamp_en_i,
  input  logic [2:0]        fmt_code_i,
  input  logic [DATA_W-1:0] lo_r_i,
  input  logic [DATA_W-1:0] hi_r_i,
  input  logic [DATA_W-1:0] lo_g_i,
  input  logic [DATA_W-1:0] hi_g_i,
  input  logic [DATA_W-1:0] lo_b_i,
  input  logic [DATA_W-1:0] hi_b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_r_o,
  output logic [DATA_W-1:0] out_g_o,
  output logic [DATA_W-1:0] out_b_o
);

  logic [NUM_CH-1:0][DATA_W-1:0] pix_in, pix_clamp, pix_q;
  logic [NUM_CH-1:0][DATA_W-1:0] prog_lo, prog_hi, lo_sel, hi_sel;
  logic                          clamp_act;
  logic                          vld_q;

  assign pix_in  = {in_b_i, in_g_i, in_r_i};
  assign prog_lo = {lo_b_i, lo_g_i, lo_r_i};
  assign prog_hi = {hi_b_i, hi_g_i, hi_r_i};

  pclamp_bound_sel #(.DATA_W(DATA_W)) u_bound_sel (
    .clamp_en_i (clamp_en_i),
    .fmt_code_i (fmt_code_i),
    .prog_lo_i  (prog_lo),
    .prog_hi_i  (prog_hi),
    .lo_o       (lo_sel),
    .hi_o       (hi_sel),
    .active_o   (clamp_act)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pclamp_comp #(.DATA_W(DATA_W)) u_comp (
      .active_i (clamp_act),
      .data_i   (pix_in[ch]),
      .lo_i     (lo_sel[ch]),
      .hi_i     (hi_sel[ch]),
      .data_o   (pix_clamp[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) pix_q <= pix_clamp;
    end
  end

  assign out_valid_o = vld_q;
  assign out_r_o     = pix_q[0];
  assign out_g_o     = pix_q[1];
  assign out_b_o     = pix_q[2];

endmodule

// File: rtl/pclamp_checker.sv
module pclamp_checker
  import pclamp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_r_i,
  input logic [DATA_W-1:0] in_g_i,
  input logic [DATA_W-1:0] in_b_i,
  input logic              clamp_en_i,
  input logic [2:0]        fmt_code_i,
  input logic [DATA_W-1:0] lo_r_i,
  input logic [DATA_W-1:0] hi_r_i,
  input logic [DATA_W-1:0] lo_g_i,
  input logic [DATA_W-1:0] hi_g_i,
  input logic [DATA_W-1:0] lo_b_i,
  input logic [DATA_W-1:0] hi_b_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_r_o,
  input logic [DATA_W-1:0] out_g_o,
  input logic [DATA_W-1:0] out_b_o
);

  localparam logic [DATA_W-1:0] STD_LO = DATA_W'(lim_lo(12, DATA_W));
  localparam logic [DATA_W-1:0] STD_HI = DATA_W'(lim_hi(12, DATA_W));

  logic pass_cfg, fixed_cfg, prog_ok;
  assign pass_cfg  = !clamp_en_i || !(fmt_code_i inside {3'd1, 3'd2, 3'd3, 3'd7});
  assign fixed_cfg = clamp_en_i && (fmt_code_i inside {3'd1, 3'd2, 3'd3});
  assign prog_ok   = clamp_en_i && fmt_code_i == 3'd7 &&
                     lo_r_i <= hi_r_i && lo_g_i <= hi_g_i && lo_b_i <= hi_b_i;

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!out_valid_o && out_r_o == '0 && out_g_o == '0 && out_b_o == '0); // R1
    end
  end

  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pass_cfg) |=>
      (out_r_o == $past(in_r_i) && out_g_o == $past(in_g_i) && out_b_o == $past(in_b_i))); // R3
  AST_FIXED_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fixed_cfg) |=>
      (out_r_o >= STD_LO && out_r_o <= STD_HI && out_g_o >= STD_LO && out_g_o <= STD_HI &&
       out_b_o >= STD_LO && out_b_o <= STD_HI)); // R5
  AST_PROG_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && prog_ok) |=>
      (out_r_o >= $past(lo_r_i) && out_r_o <= $past(hi_r_i) &&
       out_g_o >= $past(lo_g_i) && out_g_o <= $past(hi_g_i) &&
       out_b_o >= $past(lo_b_i) && out_b_o <= $past(hi_b_i))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(out_r_o) && $stable(out_g_o) && $stable(out_b_o))); // R10

endmodule

bind pixel_range_clamp pclamp_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pixel_range_clamp_tb.sv
module pixel_range_clamp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, clamp_en;
  logic [2:0]   fmt_code;
  logic [W-1:0] in_r, in_g, in_b;
  logic [W-1:0] lo_r, hi_r, lo_g, hi_g, lo_b, hi_b;
  logic         out_valid;
  logic [W-1:0] out_r, out_g, out_b;

  int checks = 0;
  int fails  = 0;
  int exp_v = 0, exp_r = 0, exp_g = 0, exp_b = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_range_clamp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_r_i(in_r), .in_g_i(in_g), .in_b_i(in_b),
    .clamp_en_i(clamp_en), .fmt_code_i(fmt_code),
    .lo_r_i(lo_r), .hi_r_i(hi_r), .lo_g_i(lo_g), .hi_g_i(hi_g),
    .lo_b_i(lo_b), .hi_b_i(hi_b),
    .out_valid_o(out_valid), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  function automatic int ref_lim(int x, int lo, int hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic int ref_comp(int x, int lo, int hi);
    if (!clamp_en) return x;
    case (fmt_code)
      3'd1, 3'd2, 3'd3: return ref_lim(x, 256, 3760);
      3'd7:             return ref_lim(x, lo, hi);
      default:          return x;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (int'(out_valid) != exp_v || int'(out_r) != exp_r ||
        int'(out_g) != exp_g || int'(out_b) != exp_b) begin
      fails++;
      $display("FAIL %s: got v=%0d r=%h g=%h b=%h, expected v=%0d r=%h g=%h b=%h",
               cur_tag, out_valid, out_r, out_g, out_b, exp_v, exp_r, exp_g, exp_b);
    end
  endtask

  task automatic step(input logic v, input int r, input int g, input int b,
                      input logic en, input int code, input string tag);
    in_valid = v; in_r = W'(r); in_g = W'(g); in_b = W'(b);
    clamp_en = en; fmt_code = 3'(code);
    exp_v = int'(v);
    if (v) begin
      exp_r = ref_comp(r, int'(lo_r), int'(hi_r));
      exp_g = ref_comp(g, int'(lo_g), int'(hi_g));
      exp_b = ref_comp(b, int'(lo_b), int'(hi_b));
    end
    cur_tag = tag;
    @(negedge clk);
    compare();
  endtask

  task automatic set_prog(input int lr, input int hr, input int lg, input int hg,
                          input int lb, input int hb);
    lo_r = W'(lr); hi_r = W'(hr); lo_g = W'(lg); hi_g = W'(hg); lo_b = W'(lb); hi_b = W'(hb);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; clamp_en = 1'b0; fmt_code = 3'd0;
    in_r = '0; in_g = '0; in_b = '0;
    set_prog(16, 4079, 16, 4079, 16, 4079);
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    compare();  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: disabled clamp passes any code
    step(1, 12'h005, 12'hFFF, 12'h800, 0, 1, "R3");
    step(1, 12'h000, 12'hFFA, 12'h123, 0, 7, "R3");
    // R4: code 0 enabled passes
    step(1, 12'hFFF, 12'h000, 12'h0FF, 1, 0, "R4");
    // R5: fixed depths
    step(1, 12'h000, 12'hFFF, 12'h800, 1, 1, "R5");
    step(1, 12'h0FF, 12'hEB1, 12'h001, 1, 2, "R5");
    step(1, 12'hFFE, 12'h050, 12'hEB0, 1, 3, "R5");
    // R8: exact bounds and interior
    step(1, 12'h100, 12'hEB0, 12'h7FF, 1, 2, "R8");
    // R7: undefined codes pass
    step(1, 12'h000, 12'hFFF, 12'h001, 1, 4, "R7");
    step(1, 12'hFFF, 12'h000, 12'hEFF, 1, 5, "R7");
    step(1, 12'h00F, 12'hF00, 12'h0F0, 1, 6, "R7");
    // R6: programmable per channel, typical values on red
    set_prog(12'h010, 12'hFEF, 12'h200, 12'h300, 12'h000, 12'h7FF);
    step(1, 12'h000, 12'h100, 12'hFFF, 1, 7, "R6");
    step(1, 12'hFFF, 12'h3FF, 12'h000, 1, 7, "R6");
    step(1, 12'h010, 12'h200, 12'h7FF, 1, 7, "R8");
    // R10: idle cycles hold outputs
    step(0, 12'h123, 12'h456, 12'h789, 1, 1, "R10");
    step(0, 12'hABC, 12'hDEF, 12'h000, 0, 0, "R10");
    // R9: inverted window, lower test first
    set_prog(12'h500, 12'h400, 12'h500, 12'h400, 12'h500, 12'h400);
    step(1, 12'h300, 12'h600, 12'h450, 1, 7, "R9");
    // R2: valid toggling
    step(1, 12'h111, 12'h222, 12'h333, 0, 0, "R2");
    step(0, 12'h000, 12'h000, 12'h000, 0, 0, "R2");
    step(1, 12'h444, 12'h555, 12'h666, 0, 0, "R2");
    // sweep across codes and values
    set_prog(12'h080, 12'hC00, 12'h300, 12'h900, 12'h010, 12'hFEF);
    for (int code = 0; code < 8; code++) begin
      for (int k = 0; k < 16; k++) begin
        step((k % 5) != 4, (k * 273) & 12'hFFF, (4095 - k * 261) & 12'hFFF,
             (k * 1031) & 12'hFFF, (k % 7) != 3, code, "R5");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule